// File: doc/BRIEF.md
# Dual-Width Indirect Register Port

This block is the host-side slave decoder for a 32-byte I/O window. The host reaches a set of control registers and a set of bus-configuration registers through one shared pointer register and two data ports. The window also holds a 16-byte read-only station address area and a reset register. Reading the reset register triggers a soft reset.

The block starts in 16-bit access mode. In that mode the host makes word accesses, and it may also read the station address area one byte at a time. The only way into 32-bit mode is a 32-bit write to the control data port, which stays at offset 10h in both modes. The new mode is sticky. A hard reset clears it, and so does an EEPROM reload, which the block sees as a load strobe plus a value. Nothing else clears it. The host interface is single-cycle, and read data is registered. Any access outside the legal map returns zero on a read, is dropped on a write, and raises a one-cycle illegal pulse.

Top module: `dwidth_reg_port`

## Requirements
- R1: After rst_ni is released, wide_mode_o, illegal_o, soft_reset_o and rdata_o are 0, and the pointer reads 0.
- R2: A read returns data on rdata_o one cycle after rd_i. If wr_i and rd_i are high together, the write wins and the read is dropped. In 16-bit mode a legal access is a word: addr_i[0]=0, with be_i=0011 when addr_i[1]=0 and be_i=1100 when addr_i[1]=1, and the data sits on the lane matching addr_i[1]. The map is: 10h control data, 12h pointer, 14h reset register, 16h bus-config data. A word write to a data port updates bits 15:0 of the register the pointer selects and keeps bits 31:16.
- R3: Offsets 00h-0Fh return the station address bytes, little-endian from ROM_VAL. Byte b sits on lane b mod 4. A byte read is a single be_i bit equal to 1<<addr_i[1:0]. In 16-bit mode both byte reads and word reads of this area are legal.
- R4: In 16-bit mode, a write at 10h with be_i=1111 writes all 32 bits to the selected control register and sets wide_mode_o on the next cycle.
- R5: Once set, the mode flag clears only on rst_ni or on eeprom_load_i, which loads eeprom_mode_i. Neither a soft reset nor setting the stop bit (bit 2 of control register 0) changes it, and neither does a write to bus-config register 18.
- R6: Bit 7 of bus-config register 18 always reads the current mode flag.
- R7: In 32-bit mode every legal access uses be_i=1111 at a 4-byte aligned address. The map is: 00h-0Fh station address, 10h control data, 14h pointer, 18h reset register, 1Ch bus-config data.
- R8: Any other access is illegal. This covers a wrong size or alignment, a reserved offset, a write to the station address area, and a 32-bit read in 16-bit mode. An illegal read returns 0, an illegal write changes nothing, and illegal_o pulses high in the cycle after the access.
- R9: A read of the reset register returns 0 and pulses soft_reset_o in the cycle after the read. It also clears the pointer. The registers and the mode flag are kept.
- R10: If the pointer is NUM_CTRL (8) or above, the control data port reads 0 and ignores writes. The bus-config port covers pointer values 0 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hard reset |
| addr_i | input | 5 | Byte address within the window |
| be_i | input | 4 | Byte enables, one per data lane |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wdata_i | input | 32 | Write data |
| eeprom_load_i | input | 1 | EEPROM reload strobe |
| eeprom_mode_i | input | 1 | Mode value delivered by the reload |
| rdata_o | output | 32 | Registered read data |
| wide_mode_o | output | 1 | 32-bit access mode flag |
| illegal_o | output | 1 | One-cycle pulse for an illegal access |
| soft_reset_o | output | 1 | One-cycle soft reset pulse |

## Verification
The assertions check four things on every cycle: the mode flag never drops without a reload, it rises only on a 32-bit write to the data port or a reload, a soft reset leaves the pointer at zero, and an illegal read returns zero. Only the bench's scenarios can show the rest. That covers the map moving between the two modes, lane placement of words and bytes, and the station address contents. It also covers dropped writes being really dropped, which the bench reads back through the pointer, and the pointer-range rule.

// File: rtl/dwp_pkg.sv
package dwp_pkg;
  typedef enum logic [2:0] {
    TGT_NONE, TGT_ROM, TGT_CTRL, TGT_PTR, TGT_SRST, TGT_CFG
  } tgt_e;

  typedef enum logic [1:0] {SZ_BAD, SZ_BYTE, SZ_WORD, SZ_DWORD} size_e;

  typedef struct packed {
    tgt_e  tgt;
    size_e size;
    logic  set_wide;
  } dec_t;
endpackage

// File: rtl/dwp_decode.sv
module dwp_decode
  import dwp_pkg::*;
(
  input  logic       wide_i,
  input  logic [4:0] addr_i,
  input  logic [3:0] be_i,
  input  logic       wr_i,
  output dec_t       dec_o
);
  size_e size;

  always_comb begin
    if (be_i == 4'hF && addr_i[1:0] == 2'b00)                  size = SZ_DWORD;
    else if (!addr_i[0] && be_i == (addr_i[1] ? 4'hC : 4'h3))  size = SZ_WORD;
    else if (be_i == (4'b0001 << addr_i[1:0]))                 size = SZ_BYTE;
    else                                                       size = SZ_BAD;
  end

  always_comb begin
    dec_o.tgt      = TGT_NONE;
    dec_o.size     = size;
    dec_o.set_wide = 1'b0;
    if (wide_i) begin
      if (size == SZ_DWORD) begin
        if (!addr_i[4]) dec_o.tgt = wr_i ? TGT_NONE : TGT_ROM;
        else begin
          unique case (addr_i[3:2])
            2'd0: dec_o.tgt = TGT_CTRL;
            2'd1: dec_o.tgt = TGT_PTR;
            2'd2: dec_o.tgt = TGT_SRST;
            default: dec_o.tgt = TGT_CFG;
          endcase
        end
      end
    end else if (!addr_i[4]) begin
      if (!wr_i && (size == SZ_WORD || size == SZ_BYTE)) dec_o.tgt = TGT_ROM;
    end else if (size == SZ_WORD) begin
      case (addr_i[3:1])
        3'd0: dec_o.tgt = TGT_CTRL;
        3'd1: dec_o.tgt = TGT_PTR;
        3'd2: dec_o.tgt = TGT_SRST;
        3'd3: dec_o.tgt = TGT_CFG;
        default: dec_o.tgt = TGT_NONE;
      endcase
    end else if (size == SZ_DWORD && wr_i && addr_i[3:0] == 4'h0) begin
      // only 32-bit op allowed in narrow mode: switches width
      dec_o.tgt      = TGT_CTRL;
      dec_o.set_wide = 1'b1;
    end
  end
endmodule

// File: rtl/dwp_regs.sv
module dwp_regs #(
  parameter int NUM_CTRL = 8,
  parameter int NUM_CFG  = 32,
  parameter int PTR_W    = 5,
  parameter int MODE_IDX = 18,
  parameter int MODE_BIT = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic             ctrl_we_i,
  input  logic             cfg_we_i,
  input  logic             full_i,
  input  logic [31:0]      wdata_i,
  input  logic             mode_i,
  output logic [31:0]      ctrl_rdata_o,
  output logic [31:0]      cfg_rdata_o
);
  localparam int CI_W = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1;
  localparam int CF_W = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1;

  logic [31:0] ctrl_q [NUM_CTRL];
  logic [31:0] cfg_q  [NUM_CFG];

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctrl_q[g] <= '0;
      else if (ctrl_we_i && int'(ptr_i) == g)
        ctrl_q[g] <= full_i ? wdata_i : {ctrl_q[g][31:16], wdata_i[15:0]};
    end
  end

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q[g] <= '0;
      else if (cfg_we_i && int'(ptr_i) == g)
        cfg_q[g] <= full_i ? wdata_i : {cfg_q[g][31:16], wdata_i[15:0]};
    end
  end

  always_comb begin
    ctrl_rdata_o = '0;
    if (int'(ptr_i) < NUM_CTRL) ctrl_rdata_o = ctrl_q[ptr_i[CI_W-1:0]];
    cfg_rdata_o = '0;
    if (int'(ptr_i) < NUM_CFG) cfg_rdata_o = cfg_q[ptr_i[CF_W-1:0]];
    if (int'(ptr_i) == MODE_IDX) cfg_rdata_o[MODE_BIT] = mode_i;
  end
endmodule

// File: rtl/dwidth_reg_port.sv
module dwidth_reg_port
  import dwp_pkg::*;
#(
  parameter int           NUM_CTRL = 8,
  parameter int           NUM_CFG  = 32,
  parameter int           MODE_IDX = 18,
  parameter int           MODE_BIT = 7,
  parameter logic [127:0] ROM_VAL  = 128'h1032_5476_98BA_DCFE_0123_4567_89AB_CDEF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [4:0]  addr_i,
  input  logic [3:0]  be_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [31:0] wdata_i,
  input  logic        eeprom_load_i,
  input  logic        eeprom_mode_i,
  output logic [31:0] rdata_o,
  output logic        wide_mode_o,
  output logic        illegal_o,
  output logic        soft_reset_o
);
  localparam int MAX_REGS = (NUM_CFG > NUM_CTRL) ? NUM_CFG : NUM_CTRL;
  localparam int PTR_W    = (MAX_REGS > 1) ? $clog2(MAX_REGS) : 1;

  dec_t             dec;
  logic             mode_q, illegal_q, srst_q;
  logic [PTR_W-1:0] ptr_q;
  logic [31:0]      rdata_q;
  logic [31:0]      ctrl_rd, cfg_rd, wval, val, rval, rom_dw, be_mask;
  logic [127:0]     rom_shift;
  logic [15:0]      lane16;
  logic             rd_eff, legal, full, set_wide_req;

  dwp_decode i_decode (
    .wide_i (mode_q),
    .addr_i (addr_i),
    .be_i   (be_i),
    .wr_i   (wr_i),
    .dec_o  (dec)
  );

  assign rd_eff       = rd_i && !wr_i;
  assign legal        = dec.tgt != TGT_NONE;
  assign full         = dec.size == SZ_DWORD;
  assign lane16       = addr_i[1] ? wdata_i[31:16] : wdata_i[15:0];
  assign wval         = full ? wdata_i : {16'h0, lane16};
  assign set_wide_req = wr_i && dec.set_wide;

  dwp_regs #(
    .NUM_CTRL (NUM_CTRL),
    .NUM_CFG  (NUM_CFG),
    .PTR_W    (PTR_W),
    .MODE_IDX (MODE_IDX),
    .MODE_BIT (MODE_BIT)
  ) i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ptr_i        (ptr_q),
    .ctrl_we_i    (wr_i && dec.tgt == TGT_CTRL),
    .cfg_we_i     (wr_i && dec.tgt == TGT_CFG),
    .full_i       (full),
    .wdata_i      (wval),
    .mode_i       (mode_q),
    .ctrl_rdata_o (ctrl_rd),
    .cfg_rdata_o  (cfg_rd)
  );

  for (genvar l = 0; l < 4; l++) begin : g_lane
    assign be_mask[8*l +: 8] = {8{be_i[l]}};
  end

  assign rom_shift = ROM_VAL >> {addr_i[3:2], 5'b0};
  assign rom_dw    = rom_shift[31:0] & be_mask;

  always_comb begin
    unique case (dec.tgt)
      TGT_CTRL: val = ctrl_rd;
      TGT_PTR:  val = {{(32-PTR_W){1'b0}}, ptr_q};
      TGT_CFG:  val = cfg_rd;
      default:  val = '0;
    endcase
    if (dec.tgt == TGT_ROM)     rval = rom_dw;
    else if (dec.size == SZ_WORD) rval = addr_i[1] ? {val[15:0], 16'h0} : {16'h0, val[15:0]};
    else                        rval = val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= 1'b0;
      ptr_q     <= '0;
      rdata_q   <= '0;
      illegal_q <= 1'b0;
      srst_q    <= 1'b0;
    end else begin
      if (eeprom_load_i)     mode_q <= eeprom_mode_i;
      else if (set_wide_req) mode_q <= 1'b1;
      if (rd_eff && dec.tgt == TGT_SRST)    ptr_q <= '0;
      else if (wr_i && dec.tgt == TGT_PTR)  ptr_q <= wval[PTR_W-1:0];
      if (rd_eff) rdata_q <= legal ? rval : '0;
      illegal_q <= (wr_i || rd_i) && !legal;
      srst_q    <= rd_eff && dec.tgt == TGT_SRST;
    end
  end

  assign rdata_o      = rdata_q;
  assign wide_mode_o  = mode_q;
  assign illegal_o    = illegal_q;
  assign soft_reset_o = srst_q;

  a_r5_mode_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && !eeprom_load_i) |=> mode_q);
  a_r4_mode_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_q) |-> $past((eeprom_load_i && eeprom_mode_i) || set_wide_req));
  a_r9_srst_clears_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q |-> ptr_q == '0);
  a_r8_illegal_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_q && $past(rd_i && !wr_i)) |-> rdata_q == '0);
endmodule

// File: tb/test_dwidth_reg_port.sv
`timescale 1ns/100ps
module test_dwidth_reg_port;
  localparam logic [127:0] ROM = 128'h1032_5476_98BA_DCFE_0123_4567_89AB_CDEF;
  localparam int NC = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] addr = '0;
  logic [3:0] be = '0;
  logic wr = 1'b0, rd = 1'b0, ld = 1'b0, ld_val = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_o;
  logic wide_mode_o, illegal_o, soft_reset_o;

  int n_chk = 0, n_bad = 0;
  logic [31:0] got_rd;
  logic got_ill, got_sr, got_mode;

  logic        m_mode;
  logic [4:0]  m_ptr;
  logic [31:0] m_ctrl [NC];
  logic [31:0] m_cfg  [32];

  always #2.5 clk = ~clk;

  dwidth_reg_port #(.ROM_VAL(ROM)) i_dwidth_reg_port (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .be_i(be), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .eeprom_load_i(ld), .eeprom_mode_i(ld_val),
    .rdata_o(rdata_o), .wide_mode_o(wide_mode_o), .illegal_o(illegal_o),
    .soft_reset_o(soft_reset_o)
  );

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // 0 bad, 1 byte, 2 word, 3 dword
  function automatic int size_of(logic [4:0] a, logic [3:0] b);
    if (b == 4'hF && a[1:0] == 0) return 3;
    if (!a[0] && b == (a[1] ? 4'hC : 4'h3)) return 2;
    if (b == (4'b1 << a[1:0])) return 1;
    return 0;
  endfunction

  // 0 illegal, 1 rom, 2 ctrl, 3 ptr, 4 reset reg, 5 cfg
  function automatic int tgt_of(logic md, logic [4:0] a, logic [3:0] b, logic w);
    int sz = size_of(a, b);
    if (md) begin
      if (sz != 3) return 0;
      if (a < 16) return w ? 0 : 1;
      return 2 + int'(a[3:2]);
    end
    if (a < 16) return (!w && (sz == 1 || sz == 2)) ? 1 : 0;
    if (sz == 2 && a < 5'h18) return 2 + int'(a[2:1]);
    if (sz == 3 && w && a == 5'h10) return 2;
    return 0;
  endfunction

  function automatic logic [31:0] read_val(int t, logic [4:0] a, logic [3:0] b);
    logic [31:0] v;
    logic [31:0] msk;
    v = 0;
    case (t)
      1: begin
        msk = {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
        return ROM[a[3:2]*32 +: 32] & msk;
      end
      2: v = (m_ptr < NC) ? m_ctrl[m_ptr[2:0]] : 32'h0;
      3: v = {27'h0, m_ptr};
      5: begin v = m_cfg[m_ptr]; if (m_ptr == 18) v[7] = m_mode; end
      default: v = 0;
    endcase
    if (size_of(a, b) == 2 && !m_mode) return a[1] ? {v[15:0], 16'h0} : {16'h0, v[15:0]};
    return v;
  endfunction

  task automatic xfer(input logic [4:0] a, input logic [3:0] b, input logic w, input logic [31:0] d);
    @(negedge clk);
    addr = a; be = b; wr = w; rd = !w; wdata = d;
    @(negedge clk);
    wr = 0; rd = 0;
    got_rd = rdata_o; got_ill = illegal_o; got_sr = soft_reset_o; got_mode = wide_mode_o;
  endtask

  task automatic access(input logic [4:0] a, input logic [3:0] b, input logic w,
                        input logic [31:0] d, input string tag);
    int t, sz;
    logic [31:0] ev;
    logic [15:0] l16;
    logic sw;
    t  = tgt_of(m_mode, a, b, w);
    sz = size_of(a, b);
    sw = !m_mode && w && t == 2 && sz == 3;
    ev = w ? 32'h0 : read_val(t, a, b);
    xfer(a, b, w, d);
    l16 = a[1] ? d[31:16] : d[15:0];
    if (w) begin
      if (t == 2 && m_ptr < NC)
        m_ctrl[m_ptr[2:0]] = (sz == 3) ? d : {m_ctrl[m_ptr[2:0]][31:16], l16};
      if (t == 3) m_ptr = (sz == 3) ? d[4:0] : l16[4:0];
      if (t == 5) m_cfg[m_ptr] = (sz == 3) ? d : {m_cfg[m_ptr][31:16], l16};
      if (sw) m_mode = 1;
    end else if (t == 4) m_ptr = 0;
    check({tag, " illegal"}, {31'h0, got_ill}, {31'h0, t == 0});
    check({tag, " soft_reset"}, {31'h0, got_sr}, {31'h0, !w && t == 4});
    if (!w) check({tag, " rdata"}, got_rd, ev);
    check({tag, " mode"}, {31'h0, got_mode}, {31'h0, m_mode});
  endtask

  task automatic eeprom(input logic v);
    @(negedge clk); ld = 1; ld_val = v;
    @(negedge clk); ld = 0;
    m_mode = v;
    check("R5 eeprom reload mode", {31'h0, wide_mode_o}, {31'h0, v});
  endtask

  task automatic hard_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    m_mode = 0; m_ptr = 0;
    for (int i = 0; i < NC; i++) m_ctrl[i] = 0;
    for (int i = 0; i < 32; i++) m_cfg[i] = 0;
    rst_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1-timeout: got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    hard_reset();
    @(negedge clk);
    // R1 reset state
    check("R1 wide_mode_o", {31'h0, wide_mode_o}, 32'h0);
    check("R1 illegal_o", {31'h0, illegal_o}, 32'h0);
    check("R1 soft_reset_o", {31'h0, soft_reset_o}, 32'h0);
    check("R1 rdata_o", rdata_o, 32'h0);
    access(5'h12, 4'hC, 0, 0, "R1 pointer");
    // R2 word map
    access(5'h12, 4'hC, 1, 32'h0003_0000, "R2 ptr write");
    access(5'h10, 4'h3, 1, 32'hDEAD_BEEF, "R2 ctrl write");
    access(5'h10, 4'h3, 0, 0, "R2 ctrl read");
    access(5'h12, 4'hC, 1, 32'h0005_0000, "R2 ptr write");
    access(5'h16, 4'hC, 1, 32'h1234_0000, "R2 cfg write");
    access(5'h16, 4'hC, 0, 0, "R2 cfg read");
    access(5'h12, 4'hC, 0, 0, "R2 ptr read");
    // R3 station address
    for (int k = 0; k < 16; k++) access(5'(k), 4'b1 << k[1:0], 0, 0, "R3 byte");
    for (int k = 0; k < 16; k += 2) access(5'(k), k[1] ? 4'hC : 4'h3, 0, 0, "R3 word");
    // R8 illegal in narrow mode
    access(5'h10, 4'hF, 0, 0, "R8 dword read narrow");
    access(5'h14, 4'hF, 1, 32'hFFFF_FFFF, "R8 dword write off 14h");
    access(5'h12, 4'hC, 0, 0, "R8 ptr unchanged");
    access(5'h18, 4'h3, 0, 0, "R8 reserved read");
    access(5'h02, 4'h3, 1, 32'h1, "R8 rom write");
    access(5'h11, 4'h3, 0, 0, "R8 misaligned");
    // R6 / R5 mode bit in cfg 18
    access(5'h12, 4'hC, 1, 32'h0012_0000, "R6 ptr 18");
    access(5'h16, 4'hC, 1, 32'hFFFF_0000, "R5 cfg18 write");
    access(5'h16, 4'hC, 0, 0, "R6 cfg18 narrow");
    // R4 switch to wide
    access(5'h12, 4'hC, 1, 32'h0, "R4 ptr 0");
    access(5'h10, 4'hF, 1, 32'hA5A5_0000, "R4 wide write");
    check("R4 wide_mode_o set", {31'h0, wide_mode_o}, 32'h1);
    access(5'h10, 4'hF, 0, 0, "R4 full value");
    // R7 wide map
    access(5'h14, 4'hF, 1, 32'd18, "R7 ptr write");
    access(5'h1C, 4'hF, 0, 0, "R6 cfg18 wide");
    access(5'h1C, 4'hF, 1, 32'h0, "R5 cfg18 clear attempt");
    access(5'h1C, 4'hF, 0, 0, "R5 mode kept");
    access(5'h14, 4'hF, 0, 0, "R7 ptr read");
    access(5'h08, 4'hF, 0, 0, "R7 rom dword");
    access(5'h10, 4'h3, 0, 0, "R8 word in wide");
    access(5'h12, 4'hC, 1, 32'h0001_0000, "R8 narrow ptr in wide");
    access(5'h14, 4'hF, 0, 0, "R8 ptr unchanged wide");
    // R5 stop bit, R9 soft reset
    access(5'h14, 4'hF, 1, 32'h0, "R5 ptr 0");
    access(5'h10, 4'hF, 1, 32'h4, "R5 stop bit");
    access(5'h14, 4'hF, 1, 32'd3, "R9 ptr 3");
    access(5'h18, 4'hF, 0, 0, "R9 reset reg read");
    access(5'h14, 4'hF, 0, 0, "R9 ptr cleared");
    access(5'h10, 4'hF, 0, 0, "R9 regs kept");
    // R10 pointer above control range
    access(5'h14, 4'hF, 1, 32'd20, "R10 ptr 20");
    access(5'h10, 4'hF, 1, 32'h7777_7777, "R10 ignored write");
    access(5'h10, 4'hF, 0, 0, "R10 read zero");
    access(5'h1C, 4'hF, 1, 32'h5555_0000, "R10 cfg 20 write");
    access(5'h1C, 4'hF, 0, 0, "R10 cfg 20 read");
    // R5 clearing paths
    eeprom(0);
    eeprom(1);
    hard_reset();
    @(negedge clk);
    check("R5 hard reset clears mode", {31'h0, wide_mode_o}, 32'h0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 60 == 0) eeprom(1'($urandom % 2));
      else begin
        logic [4:0] a;
        logic [3:0] b;
        int sel;
        a = ($urandom % 4 == 0) ? 5'h10 : 5'($urandom % 32);
        sel = $urandom % 5;
        case (sel)
          0: begin b = 4'hF; a[1:0] = 0; end
          1: begin b = a[1] ? 4'hC : 4'h3; a[0] = 0; end
          2: b = 4'b1 << a[1:0];
          3: b = 4'($urandom);
          default: b = 4'hF;
        endcase
        access(a, b, 1'($urandom % 2), $urandom, "R8 random mix");
      end
    end
    summary();
    $finish;
  end
endmodule